// File: doc/BRIEF.md
# Draw State Group Register Unit

This unit holds a table of draw state group entries behind a small set of control registers that a command processor writes. Each entry keeps a header (word count, mode mask, group index) and a 64-bit base address. A command names a target register as an offset plus a 12-bit immediate. It carries one data word and a 2-bit extra-read count N.

When the target is the set-header register, the data word becomes the header of the group it names, and that group's bit is set in the active-group mask. The N extra words then pulled from the source stream land in that group's base address, low half first. For any other target the extra words are still pulled from the stream, and they are then dropped.

Writing a group number to the select register copies that group's entry into the read-back header and read-back base outputs. A command stream therefore updates one group with three consecutive words: the header, then the base low half, then the base high half, with N = 2.

Top module: `dsg_unit`

## Requirements
- R1: A write to the set-header register (address 0x04a) stores, for the group in bits 28:24 of the data word, the count (bits 15:0) and the mode mask (bits 22:20). A later select of that group shows the word with only those three fields kept, in the same bit positions, and every other bit zero.
- R2: A set-header write sets the active-mask bit of its group in the following cycle and leaves every other mask bit unchanged. Mask bits are never cleared except by reset.
- R3: The target address is (cmd_off + cmd_imm) modulo 4096. In the cycle a command is accepted with cmd_preinc high, off_wr_en is high and off_wr_val equals that sum. With cmd_preinc low, off_wr_en stays low.
- R4: A command with N = 0 reads nothing from the source stream. busy stays low and cmd_ready stays high.
- R5: A command with N > 0 raises busy in the cycle after acceptance and holds src_ready high until N source words have been taken. While busy is high, cmd_ready is low unless the final source word is being taken in that cycle, and a missing src_valid stalls the sequence.
- R6: After a set-header write, extra word 0 becomes bits 31:0 and extra word 1 becomes bits 63:32 of the base of the group named by that header.
- R7: With N = 3, the third extra word is taken from the stream and changes no state.
- R8: For any target other than the set-header register, including the active-mask address 0x049, the N extra words are taken from the stream, and neither the mask, any entry nor the read-back outputs change.
- R9: A write to the select register (address 0x04b) loads rb_hdr and rb_base, in the following cycle, from the entry named by bits 4:0 of the data word. The upper data bits are ignored. The read-back outputs change at no other time.
- R10: A select accepted in the same cycle as the final base word of that same group returns the newly written base word.
- R11: Reset (rst_n low at a clock edge) clears the active mask, every entry and the read-back outputs to zero, and leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Register write command present |
| cmd_ready | output | 1 | Command accepted at this edge if valid |
| cmd_off | input | 12 | Current value of the offset register |
| cmd_imm | input | 12 | Immediate added to the offset |
| cmd_preinc | input | 1 | Write the sum back to the offset register |
| cmd_extra | input | 2 | Extra source reads N (0 to 3) |
| cmd_data | input | 32 | First source word, written to the target |
| off_wr_en | output | 1 | Offset register write-back strobe |
| off_wr_val | output | 12 | Offset register write-back value |
| src_valid | input | 1 | Extra source word present |
| src_ready | output | 1 | Extra source word taken at this edge if valid |
| src_data | input | 32 | Extra source word |
| busy | output | 1 | Extra reads outstanding |
| act_mask | output | 32 | Active-group bitmask |
| rb_hdr | output | 32 | Read-back header of the selected group |
| rb_base | output | 64 | Read-back base of the selected group |

## Verification
Only one case lets a base write and a select fall in the same cycle. It is the cycle in which the last extra word of a header command is taken, because that is also the cycle in which the next command can be accepted. A directed case holds src_valid with the final base word and presents, in that same cycle, a select of the group being written. It then requires cmd_ready to be high before the edge and rb_base to carry the new high word after it. Random traffic covers the rest: stalls of random length, all extra-read counts and all targets, with every read-back value compared against a model kept in the bench.

// File: rtl/dsg_pkg.sv
// Shared types and helpers for the draw state group unit.
// Assumes the 32-bit header word layout: group 28:24, mode 22:20, count 15:0.
package dsg_pkg;

    typedef struct packed {
        logic [4:0]  grp;
        logic [2:0]  mode;
        logic [15:0] count;
    } ds_hdr_t;

    typedef enum logic [1:0] {
        TGT_OTHER = 2'd0,
        TGT_HDR   = 2'd1,
        TGT_SEL   = 2'd2
    } dsg_tgt_e;

    // Extract the header fields from a raw word.
    function automatic ds_hdr_t hdr_unpack(input logic [31:0] w);
        ds_hdr_t h;
        h.grp   = w[28:24];
        h.mode  = w[22:20];
        h.count = w[15:0];
        return h;
    endfunction

    // Rebuild a word with only the header fields, other bits zero.
    function automatic logic [31:0] hdr_pack(input ds_hdr_t h);
        return {3'b000, h.grp, 1'b0, h.mode, 4'b0000, h.count};
    endfunction

endpackage

// File: rtl/dsg_decode.sv
// Address computation and target decode for one register command.
// Purely combinational; assumes the caller qualifies the strobe with acceptance.
module dsg_decode #(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] HDR_ADDR = 12'h04a,
    parameter logic [11:0] SEL_ADDR = 12'h04b
) (
    input  logic [ADDR_W-1:0] off,
    input  logic [ADDR_W-1:0] imm,
    input  logic              preinc,
    input  logic              acc,
    output dsg_pkg::dsg_tgt_e tgt,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_val
);
    import dsg_pkg::*;

    logic [ADDR_W-1:0] addr;

    // Sum the offset and immediate, then classify the target register.
    always_comb begin
        addr   = off + imm;
        wb_en  = acc && preinc;
        wb_val = addr;
        if (addr == ADDR_W'(HDR_ADDR))      tgt = TGT_HDR;
        else if (addr == ADDR_W'(SEL_ADDR)) tgt = TGT_SEL;
        else                                tgt = TGT_OTHER;
    end

endmodule

// File: rtl/dsg_seq.sv
// Extra-read sequencer: after a command with N > 0, takes N words from the
// source stream and marks which of them are base words for the header group.
// Assumes a new command is only accepted when idle or on the final handshake.
module dsg_seq #(
    parameter int EXTRA_W    = 2,
    parameter int BASE_WORDS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  logic [EXTRA_W-1:0] n,
    input  logic               to_hdr,
    input  logic               src_valid,
    output logic               busy,
    output logic               last_hs,
    output logic               base_we,
    output logic               base_word
);
    logic [EXTRA_W-1:0] wptr;
    logic [EXTRA_W-1:0] n_lat;
    logic               hdr_lat;
    logic               hs;

    // Handshake, final-word and base-write qualification.
    always_comb begin
        hs        = busy && src_valid;
        last_hs   = hs && (wptr == n_lat - EXTRA_W'(1));
        base_we   = hs && hdr_lat && (int'(wptr) < BASE_WORDS);
        base_word = wptr[0];
    end

    // Sequence state: start on a command with N > 0, advance per taken word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            wptr    <= '0;
            n_lat   <= '0;
            hdr_lat <= 1'b0;
        end else if (acc && (n != '0)) begin
            busy    <= 1'b1;
            wptr    <= '0;
            n_lat   <= n;
            hdr_lat <= to_hdr;
        end else if (last_hs) begin
            busy    <= 1'b0;
            wptr    <= '0;
        end else if (hs) begin
            wptr    <= wptr + EXTRA_W'(1);
        end
    end

    AST_ENTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (n != '0) |=> busy); // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !src_valid |=> busy && $stable(wptr)); // R5
    AST_N0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (n == '0) && !busy |=> !busy); // R4

endmodule

// File: rtl/dsg_store.sv
// Entry storage, active mask and read-back registers.
// Assumes header and select writes never arrive in the same cycle; a base
// write in the select cycle is forwarded into the read-back value.
module dsg_store #(
    parameter int NGRP  = 32,
    parameter int GRP_W = $clog2(NGRP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_we,
    input  logic [31:0]      hdr_wd,
    input  logic             sel_we,
    input  logic [GRP_W-1:0] sel_grp,
    input  logic             base_we,
    input  logic             base_word,
    input  logic [31:0]      base_data,
    output logic [NGRP-1:0]  act_mask,
    output logic [31:0]      rb_hdr,
    output logic [63:0]      rb_base
);
    import dsg_pkg::*;

    ds_hdr_t          hdr_mem [NGRP];
    logic [63:0]      base_mem [NGRP];
    logic [GRP_W-1:0] cur_grp;
    ds_hdr_t          new_hdr;
    logic [GRP_W-1:0] new_grp;
    logic [63:0]      sel_base;

    // Decode the incoming header and forward a same-cycle base write.
    always_comb begin
        new_hdr  = hdr_unpack(hdr_wd);
        new_grp  = new_hdr.grp[GRP_W-1:0];
        sel_base = base_mem[sel_grp];
        if (base_we && (cur_grp == sel_grp)) begin
            if (base_word) sel_base[63:32] = base_data;
            else           sel_base[31:0]  = base_data;
        end
    end

    // Header fields, mask bit and current group on a header write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NGRP; i++) hdr_mem[i] <= '0;
            act_mask <= '0;
            cur_grp  <= '0;
        end else if (hdr_we) begin
            hdr_mem[new_grp]  <= new_hdr;
            act_mask[new_grp] <= 1'b1;
            cur_grp           <= new_grp;
        end
    end

    // Base halves of the current group from the extra-read sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NGRP; i++) base_mem[i] <= '0;
        end else if (base_we) begin
            if (base_word) base_mem[cur_grp][63:32] <= base_data;
            else           base_mem[cur_grp][31:0]  <= base_data;
        end
    end

    // Read-back registers, loaded only by a select write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_hdr  <= '0;
            rb_base <= '0;
        end else if (sel_we) begin
            rb_hdr  <= hdr_pack(hdr_mem[sel_grp]);
            rb_base <= sel_base;
        end
    end

    AST_MASK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mask & $past(act_mask)) == $past(act_mask)); // R2
    AST_HDR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_we |=> act_mask[$past(new_grp)]); // R2
    AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we |=> $stable(rb_hdr) && $stable(rb_base)); // R9

endmodule

// File: rtl/dsg_unit.sv
// Draw state group register unit top: accepts one register command at a
// time, decodes its target, sequences the extra source reads and keeps the
// group table. Assumes cmd_data carries the first source word of the command.
module dsg_unit #(
    parameter int          NGRP     = 32,
    parameter int          ADDR_W   = 12,
    parameter int          EXTRA_W  = 2,
    parameter logic [11:0] HDR_ADDR = 12'h04a,
    parameter logic [11:0] SEL_ADDR = 12'h04b
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [ADDR_W-1:0]  cmd_off,
    input  logic [ADDR_W-1:0]  cmd_imm,
    input  logic               cmd_preinc,
    input  logic [EXTRA_W-1:0] cmd_extra,
    input  logic [31:0]        cmd_data,
    output logic               off_wr_en,
    output logic [ADDR_W-1:0]  off_wr_val,
    input  logic               src_valid,
    output logic               src_ready,
    input  logic [31:0]        src_data,
    output logic               busy,
    output logic [NGRP-1:0]    act_mask,
    output logic [31:0]        rb_hdr,
    output logic [63:0]        rb_base
);
    import dsg_pkg::*;

    localparam int GRP_W = $clog2(NGRP);

    dsg_tgt_e tgt;
    logic     acc;
    logic     last_hs;
    logic     base_we;
    logic     base_word;

    // Command acceptance: idle, or the final extra word is taken this cycle.
    always_comb begin
        cmd_ready = !busy || last_hs;
        acc       = cmd_valid && cmd_ready;
        src_ready = busy;
    end

    dsg_decode #(
        .ADDR_W  (ADDR_W),
        .HDR_ADDR(HDR_ADDR),
        .SEL_ADDR(SEL_ADDR)
    ) u_dec (
        .off   (cmd_off),
        .imm   (cmd_imm),
        .preinc(cmd_preinc),
        .acc   (acc),
        .tgt   (tgt),
        .wb_en (off_wr_en),
        .wb_val(off_wr_val)
    );

    dsg_seq #(
        .EXTRA_W   (EXTRA_W),
        .BASE_WORDS(2)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .n        (cmd_extra),
        .to_hdr   (tgt == TGT_HDR),
        .src_valid(src_valid),
        .busy     (busy),
        .last_hs  (last_hs),
        .base_we  (base_we),
        .base_word(base_word)
    );

    dsg_store #(
        .NGRP (NGRP),
        .GRP_W(GRP_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdr_we   (acc && (tgt == TGT_HDR)),
        .hdr_wd   (cmd_data),
        .sel_we   (acc && (tgt == TGT_SEL)),
        .sel_grp  (cmd_data[GRP_W-1:0]),
        .base_we  (base_we),
        .base_word(base_word),
        .base_data(src_data),
        .act_mask (act_mask),
        .rb_hdr   (rb_hdr),
        .rb_base  (rb_base)
    );

    AST_STALL_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !src_valid |-> !cmd_ready); // R5
    AST_PREINC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        off_wr_en |-> cmd_preinc && cmd_valid); // R3

endmodule

// File: tb/dsg_unit_test.sv
module dsg_unit_test;
    localparam logic [11:0] A_HDR = 12'h04a;
    localparam logic [11:0] A_SEL = 12'h04b;
    localparam logic [11:0] A_MSK = 12'h049;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready, cmd_preinc = 1'b0;
    logic [11:0] cmd_off = '0, cmd_imm = '0, off_wr_val;
    logic [1:0]  cmd_extra = '0;
    logic [31:0] cmd_data = '0, src_data = '0;
    logic        off_wr_en, src_valid = 1'b0, src_ready, busy;
    logic [31:0] act_mask, rb_hdr;
    logic [63:0] rb_base;

    always #4 clk = ~clk;

    dsg_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_off(cmd_off), .cmd_imm(cmd_imm), .cmd_preinc(cmd_preinc),
        .cmd_extra(cmd_extra), .cmd_data(cmd_data), .off_wr_en(off_wr_en),
        .off_wr_val(off_wr_val), .src_valid(src_valid), .src_ready(src_ready),
        .src_data(src_data), .busy(busy), .act_mask(act_mask),
        .rb_hdr(rb_hdr), .rb_base(rb_base)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] e_hdr [32];
    logic [63:0] e_base [32];
    logic [31:0] e_mask, e_rbh;
    logic [63:0] e_rbb;
    int          e_cur;

    function automatic logic [31:0] hdr_model(input logic [31:0] w);
        return w & 32'h1F70_FFFF;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, 64'(act_mask), 64'(e_mask));
        check(req, 64'(rb_hdr), 64'(e_rbh));
        check(req, rb_base, e_rbb);
    endtask

    // One command plus its N extra words, with stalls of 'gap' cycles.
    task automatic do_cmd(input logic [11:0] tgt, input logic pre, input int n,
                          input logic [31:0] data, input logic [31:0] w0,
                          input logic [31:0] w1, input logic [31:0] w2,
                          input int gap, input string req);
        logic [11:0] off;
        logic [31:0] words [3];
        words[0] = w0; words[1] = w1; words[2] = w2;
        off = 12'($urandom);
        @(negedge clk);
        cmd_off = off; cmd_imm = tgt - off; cmd_preinc = pre;
        cmd_extra = 2'(n); cmd_data = data; cmd_valid = 1'b1;
        #1;
        check("R4 idle ready", 64'(cmd_ready), 64'd1);
        check("R3 wb_en", 64'(off_wr_en), 64'(pre));
        if (pre) check("R3 wb_val", 64'(off_wr_val), 64'(tgt));
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        if (tgt == A_HDR) begin
            e_cur = int'(data[28:24]);
            e_hdr[e_cur] = hdr_model(data);
            e_mask[e_cur] = 1'b1;
        end else if (tgt == A_SEL) begin
            e_rbh = e_hdr[data[4:0]];
            e_rbb = e_base[data[4:0]];
        end
        if (n == 0) check("R4 no busy", 64'(busy), 64'd0);
        else        check("R5 busy", 64'(busy), 64'd1);
        for (int i = 0; i < n; i++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); #1;
                check("R5 stall busy", 64'(busy), 64'd1);
                check("R5 stall ready", 64'(cmd_ready), 64'd0);
            end
            @(negedge clk);
            src_valid = 1'b1; src_data = words[i];
            #1;
            check("R5 src_ready", 64'(src_ready), 64'd1);
            @(posedge clk); #1;
            src_valid = 1'b0;
            if (tgt == A_HDR && i == 0) e_base[e_cur][31:0]  = words[i];
            if (tgt == A_HDR && i == 1) e_base[e_cur][63:32] = words[i];
        end
        @(negedge clk); #1;
        check("R5 done", 64'(busy), 64'd0);
        check_outputs(req);
    endtask

    task automatic sel(input int g, input string req);
        do_cmd(A_SEL, 1'b0, 0, 32'(g) | 32'hABC0_0000, 0, 0, 0, 0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 32; i++) begin e_hdr[i] = '0; e_base[i] = '0; end
        e_mask = '0; e_rbh = '0; e_rbb = '0; e_cur = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R11: reset state
        check("R11 busy", 64'(busy), 64'd0);
        check_outputs("R11");
        sel(9, "R11 entry zero");

        // R1: all-ones header keeps only the three fields
        do_cmd(A_HDR, 1'b0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R1 hdr");
        sel(31, "R1 readback");
        // R6: three-word group update
        do_cmd(A_HDR, 1'b1, 2, 32'h0523_1234, 32'h1111_0000, 32'h2222_0000, 0, 1, "R6 hdr");
        sel(5, "R6 base");
        // R9: a header write does not change read-back until a select
        do_cmd(A_HDR, 1'b0, 1, 32'h0510_0007, 32'h3333_3333, 0, 0, 0, "R9 no reload");
        sel(5, "R9 reload");
        // R7: third extra word discarded
        do_cmd(A_HDR, 1'b0, 3, 32'h0300_0009, 32'hA0A0_A0A0, 32'hB0B0_B0B0, 32'hDEAD_BEEF, 2, "R7 hdr");
        sel(3, "R7 base");
        // R8: mask address and an unrelated address swallow the words
        do_cmd(A_MSK, 1'b1, 2, 32'h0000_0000, 32'h5555_5555, 32'h6666_6666, 0, 0, "R8 mask addr");
        do_cmd(12'h300, 1'b0, 3, 32'h0300_0000, 32'h7, 32'h8, 32'h9, 1, "R8 other");
        sel(3, "R8 entry intact");

        // R10: select of the group whose high base word lands in the same cycle
        @(negedge clk);
        cmd_off = '0; cmd_imm = A_HDR; cmd_preinc = 1'b0; cmd_extra = 2'd2;
        cmd_data = 32'h0740_0010; cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        e_cur = 7; e_hdr[7] = hdr_model(32'h0740_0010); e_mask[7] = 1'b1;
        @(negedge clk);
        src_valid = 1'b1; src_data = 32'hC0DE_0001;
        @(posedge clk); #1;
        @(negedge clk);
        src_data = 32'hC0DE_0002;
        cmd_imm = A_SEL; cmd_extra = 2'd0; cmd_data = 32'd7; cmd_valid = 1'b1;
        #1;
        check("R10 ready on last word", 64'(cmd_ready), 64'd1);
        @(posedge clk); #1;
        cmd_valid = 1'b0; src_valid = 1'b0;
        e_base[7] = {32'hC0DE_0002, 32'hC0DE_0001};
        e_rbh = e_hdr[7]; e_rbb = e_base[7];
        @(negedge clk); #1;
        check("R10 busy", 64'(busy), 64'd0);
        check_outputs("R10 forwarded base");

        // Random mix of targets, counts and stalls
        for (int k = 0; k < 400; k++) begin
            int r;
            logic [11:0] t;
            string tag;
            r = int'($urandom % 4);
            if (r < 2)       begin t = A_HDR; tag = "R6 random"; end
            else if (r == 2) begin t = A_SEL; tag = "R9 random"; end
            else begin
                t = ($urandom % 2 == 0) ? A_MSK : 12'($urandom % 64);
                tag = "R8 random";
            end
            do_cmd(t, 1'($urandom), int'($urandom % 4), $urandom,
                   $urandom, $urandom, $urandom, int'($urandom % 3), tag);
        end
        for (int g = 0; g < 32; g++) sel(g, "R2 R6 final sweep");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule